// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block watches for a sign of life from software and pulls a reset line when none comes. It divides a slow reference clock of nominally 32.768 kHz down to a coarse tick (one per `PRESCALE` slow cycles, 4 Hz at the default value). A small tick counter advances on each tick while the watchdog is enabled. When that counter reaches `TIMEOUT_TICKS`, a reset pulse of `PULSE_LEN` slow-clock cycles is issued and the counter starts again from zero. The timeout is therefore a whole number of tick periods.

Software services the watchdog by writing to the watchdog's bus address. The data in that write does not matter. The register decoder turns that write into a one-cycle pulse in the bus clock domain. That pulse is carried into the slow domain by a toggle synchronizer, and there it clears the tick counter. The prescaler runs freely from power-on reset, so neither a service nor a change of the enable moves the tick phase. A service that lands anywhere inside a tick period clears the counter. The reset pulse then fires on the third tick after that service, which is between two and three tick periods later.

Power-on reset clears the prescaler, the counter, the pulse generator and the synchronizer. It is active low and is sampled synchronously in both clock domains.

Top module: `wdt_core`

## Requirements
- R1: While `por_n` is 0 at a slow-clock edge, `wd_rst_o` is 0 after that edge and the tick counter is zero.
- R2: Counting slow-clock edges from the first one with `por_n` = 1, the prescaler produces a tick every `PRESCALE` edges. With `wd_en` = 1 and no service, `wd_rst_o` first reads 1 after edge `TIMEOUT_TICKS*PRESCALE + 1`.
- R3: Each reset pulse keeps `wd_rst_o` = 1 for exactly `PULSE_LEN` slow-clock cycles. Afterwards the counter is zero. With no service, successive rising edges of `wd_rst_o` are exactly `TIMEOUT_TICKS*PRESCALE` slow edges apart.
- R4: A service is `svc_i` = 1 (active high) for one `bus_clk` cycle. It clears the tick counter within four slow-clock edges. If the service falls in tick period m, where period m spans edges m*PRESCALE to (m+1)*PRESCALE-1, the next pulse rises after edge (m+`TIMEOUT_TICKS`)*PRESCALE + 1.
- R5: If services arrive no more than `TIMEOUT_TICKS`-1 tick periods apart, `wd_rst_o` stays 0.
- R6: While `wd_en` = 0, the counter is held at zero, no new pulse starts, and services have no visible effect. After `wd_en` returns to 1 in period m, the next pulse rises after edge (m+`TIMEOUT_TICKS`)*PRESCALE + 1.
- R7: Neither services nor the enable shift the prescaler phase. Every rising edge of `wd_rst_o` falls one edge after a multiple of `PRESCALE`, counted from the release of `por_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_wd | input | 1 | Slow reference clock (nominally 32.768 kHz) |
| por_n | input | 1 | Power-on reset, active low, sampled synchronously in both domains |
| wd_en | input | 1 | Watchdog enable, 1 = counting; assumed stable in the slow domain |
| bus_clk | input | 1 | Clock of the register decoder that produces the service pulse |
| svc_i | input | 1 | Service pulse, one `bus_clk` cycle high per write to the watchdog address |
| wd_rst_o | output | 1 | Reset pulse, active high, `PULSE_LEN` slow cycles long |

## Verification
The main function is driven by a table of service patterns. Each pattern places a service at a chosen offset inside a tick period after a chosen number of periods. Gaps of one or two periods must keep the reset quiet. Gaps of three or more must produce one pulse, or several, at edges computed exactly from the tick phase. Placing services at different offsets separates a design that restarts the prescaler on service from one that lets it run freely. Long unserviced gaps separate a correct repeat period from an off-by-one tick limit. Directed runs then measure pulse width and pulse spacing, show that a disabled watchdog is silent and restarts cleanly, and show that a second power-on reset restores the first-timeout timing.

// File: rtl/wdt_pkg.sv
// Shared defaults and types for the prescaled watchdog.
package wdt_pkg;
    localparam int unsigned WDT_PRESCALE_DEF = 8192;  // slow cycles per tick
    localparam int unsigned WDT_TICKS_DEF    = 3;     // ticks to timeout
    localparam int unsigned WDT_PULSE_DEF    = 4;     // reset pulse length
    localparam int unsigned WDT_SYNC_DEF     = 2;     // synchronizer depth

    typedef enum logic {
        PG_IDLE = 1'b0,
        PG_FIRE = 1'b1
    } pg_state_e;
endpackage

// File: rtl/wdt_svc_sync.sv
// Carries a one-cycle service pulse from the bus clock domain into the
// slow watchdog domain.
// The pulse is folded into a toggle, that toggle passes through STAGES
// flops, and an edge detector rebuilds a one-cycle event.
// Assumes: service pulses are spaced further apart than a few slow cycles,
// and por_n is held low for several cycles of both clocks.
module wdt_svc_sync #(
    parameter int unsigned STAGES = wdt_pkg::WDT_SYNC_DEF
) (
    input  logic bus_clk,
    input  logic clk_wd,
    input  logic por_n,
    input  logic svc_i,
    output logic evt_o
);
    logic              tgl_q;
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Bus domain: flip the toggle once per service pulse.
    always_ff @(posedge bus_clk) begin
        if (!por_n)      tgl_q <= 1'b0;
        else if (svc_i)  tgl_q <= ~tgl_q;
    end

    // Slow domain: synchronizer chain, one flop per stage.
    for (genvar g = 0; g < STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            // First stage samples the asynchronous toggle.
            always_ff @(posedge clk_wd) begin
                if (!por_n) chain_q[0] <= 1'b0;
                else        chain_q[0] <= tgl_q;
            end
        end else begin : g_next
            // Later stages pass the value down the chain.
            always_ff @(posedge clk_wd) begin
                if (!por_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    end

    // Slow domain: remember the last synchronized toggle level.
    always_ff @(posedge clk_wd) begin
        if (!por_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign evt_o = chain_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/wdt_prescaler.sv
// Free-running divider. It emits a one-cycle tick every DIV slow cycles.
// Power-on reset is the only thing that clears it, so the tick phase is
// fixed relative to the release of reset.
// Assumes: DIV >= 2.
module wdt_prescaler #(
    parameter int unsigned DIV = wdt_pkg::WDT_PRESCALE_DEF
) (
    input  logic clk_wd,
    input  logic por_n,
    output logic tick_o
);
    localparam int unsigned     PRE_W    = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

    logic [PRE_W-1:0] pre_q;

    // Count 0..DIV-1 and wrap.
    always_ff @(posedge clk_wd) begin
        if (!por_n)                pre_q <= '0;
        else if (pre_q == PRE_LAST) pre_q <= '0;
        else                       pre_q <= pre_q + 1'b1;
    end

    assign tick_o = (pre_q == PRE_LAST);
endmodule

// File: rtl/wdt_tick_ctr.sv
// Counts prescaler ticks up to LIMIT.
// It is cleared by a service event, by the enable being low, and by
// reaching LIMIT; the value LIMIT therefore lasts exactly one cycle.
// Ticks are ignored while hold_i is high (a reset pulse is running).
// Assumes: LIMIT >= 1.
module wdt_tick_ctr #(
    parameter int unsigned LIMIT = wdt_pkg::WDT_TICKS_DEF,
    localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk_wd,
    input  logic             por_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             clr_i,
    input  logic             hold_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expired_o
);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_q;

    assign expired_o = (cnt_q == LIMIT_V);

    // Advance on enabled ticks; clearing takes priority over counting.
    always_ff @(posedge clk_wd) begin
        if (!por_n)                          cnt_q <= '0;
        else if (!en_i || clr_i || expired_o) cnt_q <= '0;
        else if (tick_i && !hold_i)          cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/wdt_pulse_gen.sv
// Produces a registered reset pulse exactly LEN cycles long each time
// start_i is seen while idle.
// Assumes: LEN >= 1; a start during a pulse is ignored.
module wdt_pulse_gen #(
    parameter int unsigned LEN = wdt_pkg::WDT_PULSE_DEF
) (
    input  logic clk_wd,
    input  logic por_n,
    input  logic start_i,
    output logic pulse_o,
    output logic busy_o
);
    import wdt_pkg::*;

    localparam int unsigned     REM_W    = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [REM_W-1:0] REM_INIT = REM_W'(LEN - 1);

    pg_state_e        state_q;
    logic [REM_W-1:0] rem_q;

    // Idle -> fire on start, then count the remaining cycles down.
    always_ff @(posedge clk_wd) begin
        if (!por_n) begin
            state_q <= PG_IDLE;
            rem_q   <= '0;
        end else begin
            case (state_q)
                PG_IDLE: if (start_i) begin
                    state_q <= PG_FIRE;
                    rem_q   <= REM_INIT;
                end
                PG_FIRE: if (rem_q == '0) state_q <= PG_IDLE;
                         else             rem_q   <= rem_q - 1'b1;
                default: state_q <= PG_IDLE;
            endcase
        end
    end

    assign busy_o  = (state_q == PG_FIRE);
    assign pulse_o = busy_o;
endmodule

// File: rtl/wdt_core.sv
// Prescaled watchdog top.
// A free-running prescaler makes coarse ticks. An enabled tick counter
// fires a fixed-length reset pulse when it reaches TIMEOUT_TICKS. A
// service pulse from the bus domain, once synchronized, clears the counter.
// Assumes: wd_en is quasi-static in the clk_wd domain, and PULSE_LEN is
// smaller than PRESCALE.
module wdt_core #(
    parameter int unsigned PRESCALE      = wdt_pkg::WDT_PRESCALE_DEF,
    parameter int unsigned TIMEOUT_TICKS = wdt_pkg::WDT_TICKS_DEF,
    parameter int unsigned PULSE_LEN     = wdt_pkg::WDT_PULSE_DEF,
    parameter int unsigned SYNC_STAGES   = wdt_pkg::WDT_SYNC_DEF
) (
    input  logic clk_wd,
    input  logic por_n,
    input  logic wd_en,
    input  logic bus_clk,
    input  logic svc_i,
    output logic wd_rst_o
);
    localparam int unsigned CNT_W = $clog2(TIMEOUT_TICKS + 1);

    logic             tick;
    logic             svc_evt;
    logic             expired;
    logic             busy;
    logic             fire;
    logic [CNT_W-1:0] cnt;

    wdt_svc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .bus_clk (bus_clk),
        .clk_wd  (clk_wd),
        .por_n   (por_n),
        .svc_i   (svc_i),
        .evt_o   (svc_evt)
    );

    wdt_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk_wd (clk_wd),
        .por_n  (por_n),
        .tick_o (tick)
    );

    wdt_tick_ctr #(.LIMIT(TIMEOUT_TICKS)) u_ctr (
        .clk_wd    (clk_wd),
        .por_n     (por_n),
        .en_i      (wd_en),
        .tick_i    (tick),
        .clr_i     (svc_evt),
        .hold_i    (busy),
        .cnt_o     (cnt),
        .expired_o (expired)
    );

    // A pulse starts only if the watchdog is still enabled at expiry.
    assign fire = expired && wd_en;

    wdt_pulse_gen #(.LEN(PULSE_LEN)) u_pulse (
        .clk_wd  (clk_wd),
        .por_n   (por_n),
        .start_i (fire),
        .pulse_o (wd_rst_o),
        .busy_o  (busy)
    );
endmodule

// File: rtl/wdt_core_chk.sv
// Property checker for wdt_core, attached by bind. It observes the tick
// counter, the synchronized service event and the reset output.
module wdt_core_chk #(
    parameter int unsigned LIMIT     = wdt_pkg::WDT_TICKS_DEF,
    parameter int unsigned PULSE_LEN = wdt_pkg::WDT_PULSE_DEF,
    localparam int unsigned CNT_W    = $clog2(LIMIT + 1),
    localparam int unsigned RUN_W    = $clog2(PULSE_LEN + 2)
) (
    input logic             clk_wd,
    input logic             por_n,
    input logic             wd_en,
    input logic             svc_evt,
    input logic [CNT_W-1:0] cnt,
    input logic             wd_rst_o
);
    localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);
    localparam logic [RUN_W-1:0] PL_V  = RUN_W'(PULSE_LEN);
    localparam logic [RUN_W-1:0] RUN_M = RUN_W'(PULSE_LEN + 1);

    logic [RUN_W-1:0] run_q;

    // Length of the current high run of the reset output, saturating.
    always_ff @(posedge clk_wd) begin
        if (!por_n)        run_q <= '0;
        else if (wd_rst_o) run_q <= (run_q == RUN_M) ? run_q : run_q + 1'b1;
        else               run_q <= '0;
    end

    // R1
    por_clear_chk: assert property (@(posedge clk_wd)
        !por_n |=> (!wd_rst_o && cnt == '0));

    // R2
    cnt_bound_chk: assert property (@(posedge clk_wd) disable iff (!por_n)
        cnt <= LIM_V);

    // R2
    expire_fire_chk: assert property (@(posedge clk_wd) disable iff (!por_n)
        (cnt == LIM_V && wd_en) |=> wd_rst_o);

    // R3
    pulse_len_chk: assert property (@(posedge clk_wd) disable iff (!por_n)
        ($fell(wd_rst_o) && $past(por_n)) |-> (run_q == PL_V));

    // R3
    pulse_max_chk: assert property (@(posedge clk_wd) disable iff (!por_n)
        run_q <= PL_V);

    // R3
    pulse_zero_chk: assert property (@(posedge clk_wd) disable iff (!por_n)
        wd_rst_o |-> (cnt == '0));

    // R4
    svc_clear_chk: assert property (@(posedge clk_wd) disable iff (!por_n)
        (svc_evt && cnt != LIM_V) |=> (cnt == '0));

    // R6
    idle_hold_chk: assert property (@(posedge clk_wd) disable iff (!por_n)
        !wd_en |=> (cnt == '0));

    // R6
    fire_needs_en_chk: assert property (@(posedge clk_wd) disable iff (!por_n)
        $rose(wd_rst_o) |-> $past(wd_en));
endmodule

bind wdt_core wdt_core_chk #(
    .LIMIT     (TIMEOUT_TICKS),
    .PULSE_LEN (PULSE_LEN)
) u_chk (
    .clk_wd   (clk_wd),
    .por_n    (por_n),
    .wd_en    (wd_en),
    .svc_evt  (svc_evt),
    .cnt      (cnt),
    .wd_rst_o (wd_rst_o)
);

// File: tb/wdt_core_test.sv
// Self-checking bench for wdt_core, run with a short prescaler.
module wdt_core_test;
    localparam int DIV = 64;
    localparam int PL  = 4;
    localparam int TK  = 3;
    localparam int NV  = 8;
    // each entry: '{offset inside period, whole periods since last service}
    localparam int VEC [NV][2] = '{
        '{30, 3}, '{20, 1}, '{40, 2}, '{10, 2},
        '{45, 4}, '{12, 7}, '{33, 1}, '{25, 6}
    };

    logic clk_wd = 1'b0, bus_clk = 1'b0;
    logic por_n = 1'b0, wd_en = 1'b0, svc = 1'b0;
    logic wd_rst;

    always #2 clk_wd = ~clk_wd;    // 250 MHz
    always #3 bus_clk = ~bus_clk;

    wdt_core #(.PRESCALE(DIV), .TIMEOUT_TICKS(TK), .PULSE_LEN(PL)) uut (
        .clk_wd   (clk_wd),
        .por_n    (por_n),
        .wd_en    (wd_en),
        .bus_clk  (bus_clk),
        .svc_i    (svc),
        .wd_rst_o (wd_rst)
    );

    int n_vec = 0, n_bad = 0;
    bit done = 1'b0;

    // edges since reset release
    int edge_n = 0;
    always @(posedge clk_wd) edge_n <= por_n ? edge_n + 1 : 0;

    // rise / width monitor, sampled away from the active edge
    int rises = 0, last_rise = 0, prev_rise = 0, cur_w = 0, last_w = 0;
    bit prev_r = 1'b0;
    always @(negedge clk_wd) begin
        if (!por_n) prev_r = 1'b0;
        else begin
            if (wd_rst && !prev_r) begin
                rises++; prev_rise = last_rise; last_rise = edge_n; cur_w = 1;
            end else if (wd_rst) cur_w++;
            else if (prev_r) last_w = cur_w;
            prev_r = wd_rst;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_to(input int t);
        while (edge_n < t) @(negedge clk_wd);
    endtask

    task automatic service();
        @(negedge bus_clk) svc = 1'b1;
        @(negedge bus_clk) svc = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk_wd);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int m_prev, base, m;
        wd_en = 1'b1;
        repeat (5) @(negedge clk_wd);
        chk(wd_rst == 1'b0, "R1", "reset output during por", wd_rst, 0);
        por_n = 1'b1;

        // table walk: service patterns (R2 first timeout, R4 timing, R5 quiet)
        m_prev = 0;
        for (int i = 0; i < NV; i++) begin
            int target, exp_n, exp_last, r;
            string req;
            target = (m_prev + VEC[i][1]) * DIV + VEC[i][0];
            exp_n = 0; exp_last = 0;
            r = (m_prev + TK) * DIV + 1;
            while (r < target) begin
                exp_n++; exp_last = r; r += TK * DIV;
            end
            base = rises;
            wait_to(target);
            req = (exp_n == 0) ? "R5" : ((i == 0) ? "R2" : "R4");
            chk(rises - base == exp_n, req, "pulse count", rises - base, exp_n);
            if (exp_n > 0)
                chk(last_rise == exp_last, req, "last pulse edge", last_rise, exp_last);
            service();
            m_prev = target / DIV;
        end

        // R3 / R7: free-running pulses, width and spacing
        wait_to((m_prev + 2 * TK) * DIV + 10);
        chk(last_w == PL, "R3", "pulse width", last_w, PL);
        chk(last_rise - prev_rise == TK * DIV, "R3", "pulse spacing",
            last_rise - prev_rise, TK * DIV);
        chk(last_rise % DIV == 1, "R7", "pulse phase", last_rise % DIV, 1);

        // R6: disabled watchdog is silent, ignores service, restarts from zero
        m = edge_n / DIV;
        wait_to((m + 1) * DIV + 20);
        wd_en = 1'b0;
        base = rises;
        wait_to((m + 4) * DIV + 20);
        service();
        wait_to((m + 8) * DIV + 20);
        chk(rises == base, "R6", "pulses while disabled", rises - base, 0);
        wd_en = 1'b1;
        wait_to((m + 11) * DIV + 10);
        chk(rises - base == 1, "R6", "pulses after re-enable", rises - base, 1);
        chk(last_rise == (m + 11) * DIV + 1, "R6", "re-enable pulse edge",
            last_rise, (m + 11) * DIV + 1);

        // R1 / R2: second power-on reset restarts timing
        m = edge_n / DIV;
        wait_to((m + 1) * DIV + 20);
        por_n = 1'b0;
        repeat (3) @(negedge clk_wd);
        chk(wd_rst == 1'b0, "R1", "reset output during second por", wd_rst, 0);
        base = rises;
        por_n = 1'b1;
        wait_to(3 * DIV + 10);
        chk(rises - base == 1, "R2", "pulses after por", rises - base, 1);
        chk(last_rise == TK * DIV + 1, "R2", "first pulse edge after por",
            last_rise, TK * DIV + 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule